// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit Load/Store Pipeline

This block is the combinational arithmetic, logic, shift and compare stage of a five-stage 32-bit pipeline. The decode stage hands it an operation code, the two register operands (the rs value as `srcA`, the rt value as `srcB`), the raw 16-bit immediate, the 5-bit shift-amount field, and the destination register index with its decoded write enable. Within the same cycle it returns the value to write, the destination index and the final write enable.

The block extends the immediate itself, with sign or zero extension chosen by the operation. It checks the signed add and subtract forms for two's-complement overflow. When an overflow is found it withholds the register write, so the destination keeps its old value. The unsigned forms wrap silently. A small control decoder turns the operation code into a struct of strobes, and a datapath acts on those strobes. Memory access, branches, multiply/divide and the register file are handled elsewhere in the pipeline.

Top module: `int_exec_unit`

## Requirements
- R1: `opCode` encoding: 0 add, 1 addu, 2 sub, 3 subu, 4 and, 5 or, 6 xor, 7 nor, 8 slt, 9 sltu, 10 sll, 11 srl, 12 sra, 13 sllv, 14 srlv, 15 srav, 16 addi, 17 addiu, 18 andi, 19 ori, 20 xori, 21 lui, 22 slti, 23 sltiu; codes 24 to 31 never assert `wrEnOut`.
- R2: addu, subu and addiu wrap modulo 2^32 and never suppress the write (0x80000010 + 0x80000001 gives 0x00000011).
- R3: add and addi drop `wrEnOut` when both addends share a sign and the sum's sign differs. sub drops it when the operands differ in sign and the result's sign differs from `srcA`.
- R4: addi, addiu, slti and sltiu use the sign-extended immediate. andi, ori and xori use the zero-extended immediate (addiu of 0 and 0x8000 gives 0xffff8000; ori of 0 and 0x8000 gives 0x00008000).
- R5: lui returns the immediate in bits 31:16 with bits 15:0 cleared, ignoring `srcA`.
- R6: and, or, xor and nor act bitwise on `srcA` and `srcB`, and nor returns the inverse of their OR.
- R7: sll and srl shift `srcB` by `shamtIn`, filling with zeros.
- R8: sra and srav shift `srcB` right and replicate bit 31 into the vacated bits.
- R9: sllv, srlv and srav shift `srcB` by the low 5 bits of `srcA` only.
- R10: slt and slti compare signed, and sltu and sltiu compare unsigned. The result is 1 or 0 (0xffff0000 vs 0 gives 1 signed and 0 unsigned).
- R11: `destOut` equals `destIn`, including index 0. `wrEnOut` is never high while `wrEnIn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 5 | Decoded operation code (R1 encoding) |
| srcA | input | 32 | rs operand value |
| srcB | input | 32 | rt operand value |
| immIn | input | 16 | Raw immediate field |
| shamtIn | input | 5 | Fixed shift amount field |
| destIn | input | 5 | Destination register index from decode |
| wrEnIn | input | 1 | Decoded register write enable |
| result | output | 32 | Value to write back |
| destOut | output | 5 | Destination register index |
| wrEnOut | output | 1 | Final write enable after overflow and opcode checks |

## Verification
The assertions assume that the operation code and operands are stable and settled when the combinational checks are evaluated. They also assume that immediate-form operations present their second operand on `immIn`, not on `srcB`. The overflow checks for add and sub read the `srcB` port, so they are meaningful only for the register forms. The bench changes inputs once per clock, well after the edge, and samples only at the following falling edge. For immediate forms it still drives `srcB` with unrelated values, so a wrong operand selection shows up in the result.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU = 5'd3,
    OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_NOR  = 5'd7,
    OP_SLT   = 5'd8,  OP_SLTU  = 5'd9,  OP_SLL   = 5'd10, OP_SRL  = 5'd11,
    OP_SRA   = 5'd12, OP_SLLV  = 5'd13, OP_SRLV  = 5'd14, OP_SRAV = 5'd15,
    OP_ADDI  = 5'd16, OP_ADDIU = 5'd17, OP_ANDI  = 5'd18, OP_ORI  = 5'd19,
    OP_XORI  = 5'd20, OP_LUI   = 5'd21, OP_SLTI  = 5'd22, OP_SLTIU = 5'd23
  } exu_op_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOR, FN_SLT, FN_SHL, FN_SHR, FN_LUI
  } exu_fn_e;

  typedef enum logic [1:0] {
    BSEL_REG, BSEL_SEXT, BSEL_ZEXT
  } exu_bsel_e;

  typedef struct packed {
    exu_fn_e   fn;
    exu_bsel_e bSel;
    logic      shVar;
    logic      shArith;
    logic      cmpSigned;
    logic      trapOvf;
    logic      opValid;
  } exu_ctl_t;

endpackage

// File: rtl/exu_control.sv
module exu_control
  import exu_pkg::*;
(
  input  logic [4:0] opCode,
  output exu_ctl_t   ctl
);

  exu_op_e opDec;
  assign opDec = exu_op_e'(opCode);

  always_comb begin
    ctl           = '0;
    ctl.fn        = FN_ADD;
    ctl.bSel      = BSEL_REG;
    ctl.opValid   = 1'b1;
    case (opDec)
      OP_ADD:   begin ctl.fn = FN_ADD; ctl.trapOvf = 1'b1; end
      OP_ADDU:  ctl.fn = FN_ADD;
      OP_SUB:   begin ctl.fn = FN_SUB; ctl.trapOvf = 1'b1; end
      OP_SUBU:  ctl.fn = FN_SUB;
      OP_AND:   ctl.fn = FN_AND;
      OP_OR:    ctl.fn = FN_OR;
      OP_XOR:   ctl.fn = FN_XOR;
      OP_NOR:   ctl.fn = FN_NOR;
      OP_SLT:   begin ctl.fn = FN_SLT; ctl.cmpSigned = 1'b1; end
      OP_SLTU:  ctl.fn = FN_SLT;
      OP_SLL:   ctl.fn = FN_SHL;
      OP_SRL:   ctl.fn = FN_SHR;
      OP_SRA:   begin ctl.fn = FN_SHR; ctl.shArith = 1'b1; end
      OP_SLLV:  begin ctl.fn = FN_SHL; ctl.shVar = 1'b1; end
      OP_SRLV:  begin ctl.fn = FN_SHR; ctl.shVar = 1'b1; end
      OP_SRAV:  begin ctl.fn = FN_SHR; ctl.shVar = 1'b1; ctl.shArith = 1'b1; end
      OP_ADDI:  begin ctl.fn = FN_ADD; ctl.bSel = BSEL_SEXT; ctl.trapOvf = 1'b1; end
      OP_ADDIU: begin ctl.fn = FN_ADD; ctl.bSel = BSEL_SEXT; end
      OP_ANDI:  begin ctl.fn = FN_AND; ctl.bSel = BSEL_ZEXT; end
      OP_ORI:   begin ctl.fn = FN_OR;  ctl.bSel = BSEL_ZEXT; end
      OP_XORI:  begin ctl.fn = FN_XOR; ctl.bSel = BSEL_ZEXT; end
      OP_LUI:   ctl.fn = FN_LUI;
      OP_SLTI:  begin ctl.fn = FN_SLT; ctl.bSel = BSEL_SEXT; ctl.cmpSigned = 1'b1; end
      OP_SLTIU: begin ctl.fn = FN_SLT; ctl.bSel = BSEL_SEXT; end
      default:  ctl.opValid = 1'b0;
    endcase
  end

  // R1: unassigned codes must not be flagged valid
  always_comb begin
    if (opCode >= 5'd24) assert_bad_op_invalid_R1: assert (!ctl.opValid);
  end

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  exu_ctl_t             ctl,
  input  logic [DATA_W-1:0]    srcA,
  input  logic [DATA_W-1:0]    srcB,
  input  logic [IMM_W-1:0]     immIn,
  input  logic [SH_W-1:0]      shamtIn,
  input  logic                 wrEnIn,
  output logic [DATA_W-1:0]    result,
  output logic                 wrEnOut
);

  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immSext, immZext, immHigh, opB;
  logic [DATA_W-1:0] addRes, subRes, shlRes, shrRes;
  logic [SH_W-1:0]   shAmt;
  logic              ovfAdd, ovfSub, ovfHit, lessThan;

  assign immSext = {{EXT_W{immIn[IMM_W-1]}}, immIn};
  assign immZext = {{EXT_W{1'b0}}, immIn};

  generate
    if (EXT_W >= IMM_W) begin : g_lui_wide
      assign immHigh = {immIn, {EXT_W{1'b0}}};
    end else begin : g_lui_narrow
      assign immHigh = {immIn[IMM_W-1 -: EXT_W], {IMM_W{1'b0}}} >> 0;
    end
  endgenerate

  always_comb begin
    case (ctl.bSel)
      BSEL_SEXT: opB = immSext;
      BSEL_ZEXT: opB = immZext;
      default:   opB = srcB;
    endcase
  end

  assign addRes = srcA + opB;
  assign subRes = srcA - opB;
  assign ovfAdd = (srcA[MSB] == opB[MSB]) && (addRes[MSB] != srcA[MSB]);
  assign ovfSub = (srcA[MSB] != opB[MSB]) && (subRes[MSB] != srcA[MSB]);

  assign shAmt  = ctl.shVar ? srcA[SH_W-1:0] : shamtIn;
  assign shlRes = srcB << shAmt;
  assign shrRes = ctl.shArith ? DATA_W'($signed(srcB) >>> shAmt) : (srcB >> shAmt);

  assign lessThan = ctl.cmpSigned ? ($signed(srcA) < $signed(opB)) : (srcA < opB);

  always_comb begin
    case (ctl.fn)
      FN_ADD:  result = addRes;
      FN_SUB:  result = subRes;
      FN_AND:  result = srcA & opB;
      FN_OR:   result = srcA | opB;
      FN_XOR:  result = srcA ^ opB;
      FN_NOR:  result = ~(srcA | opB);
      FN_SLT:  result = {{(DATA_W-1){1'b0}}, lessThan};
      FN_SHL:  result = shlRes;
      FN_SHR:  result = shrRes;
      FN_LUI:  result = immHigh;
      default: result = '0;
    endcase
  end

  always_comb begin
    ovfHit = 1'b0;
    if (ctl.trapOvf) ovfHit = (ctl.fn == FN_SUB) ? ovfSub : ovfAdd;
  end

  assign wrEnOut = wrEnIn & ctl.opValid & ~ovfHit;

  // R8: arithmetic right shift of a negative value keeps the sign bit set
  always_comb begin
    if (ctl.fn == FN_SHR && ctl.shArith && srcB[MSB])
      assert_sra_sign_R8: assert (result[MSB]);
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immIn,
  input  logic [SH_W-1:0]   shamtIn,
  input  logic [IDX_W-1:0]  destIn,
  input  logic              wrEnIn,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  destOut,
  output logic              wrEnOut
);

  localparam int MSB = DATA_W - 1;

  exu_ctl_t ctl;

  exu_control u_control (
    .opCode (opCode),
    .ctl    (ctl)
  );

  exu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_datapath (
    .ctl     (ctl),
    .srcA    (srcA),
    .srcB    (srcB),
    .immIn   (immIn),
    .shamtIn (shamtIn),
    .wrEnIn  (wrEnIn),
    .result  (result),
    .wrEnOut (wrEnOut)
  );

  assign destOut = destIn;

  always_comb begin
    // R11: no write can appear that decode did not request
    if (wrEnOut) assert_we_gated_R11: assert (wrEnIn);
    // R1: unassigned codes never write
    if (opCode >= 5'd24) assert_bad_op_R1: assert (!wrEnOut);
    // R5: lui clears the low half
    if (opCode == OP_LUI) assert_lui_low_R5: assert (result[IMM_W-1:0] == '0);
    // R10: compares produce only 0 or 1
    if (opCode == OP_SLT || opCode == OP_SLTU || opCode == OP_SLTI || opCode == OP_SLTIU)
      assert_cmp_bool_R10: assert (result[MSB:1] == '0);
    // R2: unsigned arithmetic never drops a requested write
    if ((opCode == OP_ADDU || opCode == OP_SUBU || opCode == OP_ADDIU) && wrEnIn)
      assert_unsigned_wrap_R2: assert (wrEnOut);
    // R3: signed overflow on register add/sub suppresses the write
    if (opCode == OP_ADD && srcA[MSB] == srcB[MSB] && result[MSB] != srcA[MSB])
      assert_no_overflow_R3: assert (!wrEnOut);
    if (opCode == OP_SUB && srcA[MSB] != srcB[MSB] && result[MSB] != srcA[MSB])
      assert_no_overflow_sub_R3: assert (!wrEnOut);
  end

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  localparam logic [4:0] C_ADD = 5'd0,  C_ADDU = 5'd1,  C_SUB = 5'd2,  C_SUBU = 5'd3;
  localparam logic [4:0] C_AND = 5'd4,  C_OR = 5'd5,    C_XOR = 5'd6,  C_NOR = 5'd7;
  localparam logic [4:0] C_SLT = 5'd8,  C_SLTU = 5'd9,  C_SLL = 5'd10, C_SRL = 5'd11;
  localparam logic [4:0] C_SRA = 5'd12, C_SLLV = 5'd13, C_SRLV = 5'd14, C_SRAV = 5'd15;
  localparam logic [4:0] C_ADDI = 5'd16, C_ADDIU = 5'd17, C_ANDI = 5'd18, C_ORI = 5'd19;
  localparam logic [4:0] C_XORI = 5'd20, C_LUI = 5'd21, C_SLTI = 5'd22, C_SLTIU = 5'd23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  opCode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [15:0] immIn = '0;
  logic [4:0]  shamtIn = '0, destIn = '0;
  logic        wrEnIn = 1'b0;
  logic [31:0] result;
  logic [4:0]  destOut;
  logic        wrEnOut;

  int_exec_unit u_int_exec_unit (
    .opCode (opCode), .srcA (srcA), .srcB (srcB), .immIn (immIn),
    .shamtIn (shamtIn), .destIn (destIn), .wrEnIn (wrEnIn),
    .result (result), .destOut (destOut), .wrEnOut (wrEnOut)
  );

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [4:0]  dst;
    logic        chkRes;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   doneFlag = 1'b0;

  task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input logic [4:0] d,
                       input logic we, input logic [31:0] eRes, input logic eWe,
                       input logic chk, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    opCode = op; srcA = a; srcB = b; immIn = im; shamtIn = sh; destIn = d; wrEnIn = we;
    e.res = eRes; e.we = eWe; e.dst = d; e.chkRes = chk; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compares at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nChecks++;
        if (wrEnOut !== e.we || destOut !== e.dst || (e.chkRes && result !== e.res)) begin
          nFails++;
          $display("FAIL %s: result=%h we=%b dest=%0d expected result=%h we=%b dest=%0d",
                   e.tag, result, wrEnOut, destOut, e.res, e.we, e.dst);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!doneFlag) begin
      doneFlag = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // reset state: all-zero inputs, nothing written (R11)
    drive(C_ADD, 0, 0, 0, 0, 0, 1'b0, 32'h0, 1'b0, 1'b1, "R11 reset idle");
    rstN = 1'b1;

    // R2 unsigned wrap
    drive(C_ADDU, 32'h80000010, 32'h80000001, 0, 0, 3, 1, 32'h00000011, 1, 1, "R2 addu wrap");
    drive(C_SUBU, 32'h80000010, 32'h80000001, 0, 0, 3, 1, 32'h0000000f, 1, 1, "R2 subu");
    // R3 signed overflow
    drive(C_ADD, 32'h80000010, 32'h80000001, 0, 0, 3, 1, 32'h0, 0, 0, "R3 add overflow");
    drive(C_ADD, 32'd5, 32'd7, 0, 0, 3, 1, 32'd12, 1, 1, "R3 add no overflow");
    drive(C_SUB, 32'h80000000, 32'd1, 0, 0, 3, 1, 32'h0, 0, 0, "R3 sub overflow");
    drive(C_SUB, 32'h80000010, 32'd0, 0, 0, 3, 1, 32'h80000010, 1, 1, "R3 sub no overflow");
    drive(C_ADDI, 32'h7fffffff, 32'h0, 16'h0001, 0, 3, 1, 32'h0, 0, 0, "R3 addi overflow");
    drive(C_ADDI, 32'h0000000f, 32'hdead0000, 16'h0002, 0, 3, 1, 32'h11, 1, 1, "R3 addi");
    // R4 immediate extension
    drive(C_ADDIU, 32'h0, 32'h12345678, 16'h8000, 0, 3, 1, 32'hffff8000, 1, 1, "R4 addiu sext");
    drive(C_ORI, 32'h0, 32'hffffffff, 16'h8000, 0, 4, 1, 32'h00008000, 1, 1, "R4 ori zext");
    drive(C_ANDI, 32'h01011101, 32'hffffffff, 16'h00fe, 0, 4, 1, 32'h0, 1, 1, "R4 andi zext");
    drive(C_XORI, 32'h0, 32'h0, 16'hff00, 0, 4, 1, 32'h0000ff00, 1, 1, "R4 xori zext");
    // R5 lui
    drive(C_LUI, 32'hffffffff, 32'hffffffff, 16'h0101, 0, 1, 1, 32'h01010000, 1, 1, "R5 lui");
    // R6 logic
    drive(C_OR, 32'h01010101, 32'h01011101, 0, 0, 1, 1, 32'h01011101, 1, 1, "R6 or");
    drive(C_AND, 32'hf0f0f0f0, 32'hff00ff00, 0, 0, 1, 1, 32'hf000f000, 1, 1, "R6 and");
    drive(C_XOR, 32'hf0f0f0f0, 32'hff00ff00, 0, 0, 1, 1, 32'h0ff00ff0, 1, 1, "R6 xor");
    drive(C_NOR, 32'h0000ff00, 32'h0000ff00, 0, 0, 1, 1, 32'hffff00ff, 1, 1, "R6 nor");
    // R7 logical shifts by field
    drive(C_SLL, 32'hffffffff, 32'h04040404, 0, 5'd8, 2, 1, 32'h04040400, 1, 1, "R7 sll");
    drive(C_SRL, 32'hffffffff, 32'h02020000, 0, 5'd8, 2, 1, 32'h00020200, 1, 1, "R7 srl");
    drive(C_SRL, 32'h0, 32'h80000000, 0, 5'd31, 2, 1, 32'h00000001, 1, 1, "R7 srl zero fill");
    // R8 arithmetic shifts
    drive(C_SRA, 32'h0, 32'h80800000, 0, 5'd16, 2, 1, 32'hffff8080, 1, 1, "R8 sra");
    drive(C_SRAV, 32'd8, 32'hffff8080, 0, 5'd0, 2, 1, 32'hffffff80, 1, 1, "R8 srav");
    // R9 variable shifts
    drive(C_SLLV, 32'd7, 32'h04040400, 0, 5'd3, 2, 1, 32'h02020000, 1, 1, "R9 sllv");
    drive(C_SRLV, 32'd5, 32'h00020200, 0, 5'd9, 2, 1, 32'h00001010, 1, 1, "R9 srlv");
    drive(C_SRLV, 32'h25, 32'h00020200, 0, 5'd0, 2, 1, 32'h00001010, 1, 1, "R9 srlv low bits");
    // R10 compares
    drive(C_SLT, 32'hffff0000, 32'h0, 0, 0, 2, 1, 32'd1, 1, 1, "R10 slt signed");
    drive(C_SLTU, 32'hffff0000, 32'h0, 0, 0, 2, 1, 32'd0, 1, 1, "R10 sltu unsigned");
    drive(C_SLTI, 32'hffff0000, 32'h0, 16'h0001, 0, 2, 1, 32'd1, 1, 1, "R10 slti");
    drive(C_SLTIU, 32'hffff0000, 32'h0, 16'h0001, 0, 2, 1, 32'd0, 1, 1, "R10 sltiu");
    drive(C_SLTIU, 32'd5, 32'h0, 16'hffff, 0, 2, 1, 32'd1, 1, 1, "R10 sltiu sext imm");
    // R11 pass-through
    drive(C_ADDU, 32'd1, 32'd2, 0, 0, 5'd9, 0, 32'd3, 0, 1, "R11 no decode write");
    drive(C_ADDU, 32'd1, 32'd2, 0, 0, 5'd0, 1, 32'd3, 1, 1, "R11 register 0");
    // R1 unassigned codes
    drive(5'd24, 32'd1, 32'd2, 0, 0, 5'd4, 1, 32'd0, 0, 0, "R1 code 24");
    drive(5'd31, 32'd1, 32'd2, 0, 0, 5'd4, 1, 32'd0, 0, 0, "R1 code 31");

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule